// File: doc/BRIEF.md
# PLL Synthesizer Serial Programmer

This block programs an external frequency-synthesizer chip through a three-wire serial link: a serial clock, a data line and a latch-enable strobe. A one-cycle `start` pulse launches a fixed start-up sequence of four 21-bit register loads. The first load is a constant reference word. The second is a divider word built from the requested channel number. The last two are constant function words. Each word is shifted out most-significant bit first and committed by a latch pulse.

The channel number is the total divide count at a 12.5 kHz comparison step. The block splits it into a swallow count A (the remainder modulo 32) and a main count B (the quotient by 32). It packs these with a fixed control code, and it can also set a go flag in the top bit. Serial timing is set by three parameters counted in system clocks: `HOLD_CYC` (clock-low time before data moves, clock-high time, and the tail before the latch), `SETUP_CYC` (data valid before the rising clock edge) and `LATCH_CYC` (latch pulse width). Each of the three must be at least 1.

The sequencer states are IDLE, LOAD, CLK_LO, SETUP, CLK_HI, TAIL, LATCH and FINISH. It moves through them as follows:
- IDLE goes to LOAD on `start`.
- LOAD goes to CLK_LO.
- CLK_LO goes to SETUP when its timer expires.
- SETUP goes to CLK_HI when its timer expires.
- CLK_HI goes back to CLK_LO for the next bit, or to TAIL after bit 0.
- TAIL goes to LATCH.
- LATCH goes to LOAD for the next word, or to FINISH after the fourth word.
- FINISH goes to IDLE.

Top module: `pll_serial_loader`

## Requirements
- R1: Each word is exactly 21 bits and is sent starting at bit 20, ending at bit 0. One bit is sent per rising edge of `ser_clk`.
- R2: For every bit, the following happens in order:
  - `ser_clk` is low for HOLD_CYC cycles with the previous data value.
  - `ser_data` then takes the new bit and stays low-clocked for SETUP_CYC cycles.
  - `ser_clk` is high for HOLD_CYC cycles, and `ser_data` is stable the whole time it is high.
- R3: `ser_le` is low for the whole time a word is being shifted.
- R4: After bit 0, `ser_clk` stays low for HOLD_CYC cycles. `ser_le` is then high for LATCH_CYC cycles and returns low. `ser_le` is never high while `ser_clk` is high.
- R5: The divider word has the value 01 in bits [1:0], A = chan mod 32 in bits [6:2], and B = chan / 32 in bits [20:7].
- R6: When `go` is 1 at the time of start, bit 20 of the divider word is forced to 1. This is OR-ed with the B count.
- R7: The words are sent in this order: 0x001500, the divider word, 0x000093, 0x000092. Each word is preceded by one LOAD cycle in which `ser_clk`, `ser_le` and `ser_data` are all low.
- R8: `busy` is high from the cycle after `start` is accepted until the end of the last latch pulse. A `start` pulse while busy, or in the FINISH cycle, has no effect.
- R9: `done` is high for exactly one cycle, directly after the last latch pulse ends, and `busy` is low in that cycle.
- R10: A synchronous active-high `rst` drives `ser_clk`, `ser_data` and `ser_le` low and returns the sequencer to IDLE, including in the middle of a sequence.
- R11: `chan` and `go` are captured when `start` is accepted. Changes to them during a sequence have no effect on the words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the four-word sequence when idle |
| chan | input | 19 | Total divide count (channel number at 12.5 kHz step) |
| go | input | 1 | Sets the go flag (bit 20) of the divider word |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_le | output | 1 | Latch-enable strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
The assertions assume `start` is a synchronous, one-cycle-wide level and that the timing parameters are at least 1. This assumption is what makes every state last at least a cycle, so a data edge can never coincide with a clock edge. The bench drives `start`, `chan` and `go` only on falling system-clock edges. It raises `start` deliberately in the middle of a sequence and in the FINISH cycle. It also changes `chan` and `go` while busy, and applies reset in the middle of a word, so the ignore and capture rules are exercised within those assumptions.

// File: rtl/pll_ldr_pkg.sv
package pll_ldr_pkg;
    localparam int WORD_W  = 21;
    localparam int A_W     = 5;
    localparam int N_WORDS = 4;
    localparam int WIDX_W  = $clog2(N_WORDS);
    localparam int CHAN_W  = WORD_W - 2;

    localparam logic [WORD_W-1:0] REF_WORD   = 21'h001500;
    localparam logic [WORD_W-1:0] FUNC_WORD0 = 21'h000093;
    localparam logic [WORD_W-1:0] FUNC_WORD1 = 21'h000092;
    localparam logic [1:0]        NCTRL      = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_CLK_LO, ST_SETUP,
        ST_CLK_HI, ST_TAIL, ST_LATCH, ST_FINISH
    } ldr_state_e;
endpackage

// File: rtl/pll_nword.sv
module pll_nword
    import pll_ldr_pkg::*;
(
    input  logic [CHAN_W-1:0] chan,
    input  logic              go,
    output logic [WORD_W-1:0] nword
);
    localparam int B_W = CHAN_W - A_W;

    logic [A_W-1:0] a_cnt;
    logic [B_W-1:0] b_cnt;
    logic [WORD_W-1:0] raw;

    always_comb begin
        a_cnt = chan[A_W-1:0];                        // remainder by 2**A_W
        b_cnt = B_W'(chan >> A_W);                    // quotient by 2**A_W
        raw   = {b_cnt, a_cnt, NCTRL};
        nword = raw | {go, {(WORD_W-1){1'b0}}};
    end
endmodule

// File: rtl/pll_word_sel.sv
module pll_word_sel
    import pll_ldr_pkg::*;
(
    input  logic [WIDX_W-1:0] idx,
    input  logic [WORD_W-1:0] nword,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        unique case (idx)
            2'd0: word = REF_WORD;
            2'd1: word = nword;
            2'd2: word = FUNC_WORD0;
            2'd3: word = FUNC_WORD1;
        endcase
    end
endmodule

// File: rtl/pll_tmr.sv
module pll_tmr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pll_serial_loader.sv
module pll_serial_loader
    import pll_ldr_pkg::*;
#(
    parameter int SETUP_CYC = 4,
    parameter int HOLD_CYC  = 2,
    parameter int LATCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CHAN_W-1:0] chan,
    input  logic              go,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le,
    output logic              busy,
    output logic              done
);
    localparam int MAX_CYC = (SETUP_CYC > HOLD_CYC)
                           ? ((SETUP_CYC > LATCH_CYC) ? SETUP_CYC : LATCH_CYC)
                           : ((HOLD_CYC  > LATCH_CYC) ? HOLD_CYC  : LATCH_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(N_WORDS - 1);
    localparam logic [CNT_W-1:0]  T_HOLD    = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0]  T_SETUP   = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0]  T_LATCH   = CNT_W'(LATCH_CYC - 1);

    ldr_state_e state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [WIDX_W-1:0] word_q;
    logic [WORD_W-1:0] sh_q;
    logic              dat_q;
    logic [CHAN_W-1:0] chan_q;
    logic              go_q;
    logic              tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_val;
    logic [WORD_W-1:0] nword, cur_word;

    pll_nword u_nword (.chan(chan_q), .go(go_q), .nword(nword));

    pll_word_sel u_sel (.idx(word_q), .nword(nword), .word(cur_word));

    pll_tmr #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    // next state and timer reload
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_LOAD;
            ST_LOAD: begin
                state_d  = ST_CLK_LO;
                tmr_load = 1'b1;
                tmr_val  = T_HOLD;
            end
            ST_CLK_LO: if (tmr_exp) begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = T_SETUP;
            end
            ST_SETUP: if (tmr_exp) begin
                state_d  = ST_CLK_HI;
                tmr_load = 1'b1;
                tmr_val  = T_HOLD;
            end
            ST_CLK_HI: if (tmr_exp) begin
                state_d  = (bit_q == LAST_BIT) ? ST_TAIL : ST_CLK_LO;
                tmr_load = 1'b1;
                tmr_val  = T_HOLD;
            end
            ST_TAIL: if (tmr_exp) begin
                state_d  = ST_LATCH;
                tmr_load = 1'b1;
                tmr_val  = T_LATCH;
            end
            ST_LATCH: if (tmr_exp)
                state_d = (word_q == LAST_WORD) ? ST_FINISH : ST_LOAD;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q  <= '0;
            word_q <= '0;
            sh_q   <= '0;
            dat_q  <= 1'b0;
            chan_q <= '0;
            go_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    chan_q <= chan;
                    go_q   <= go;
                    word_q <= '0;
                    dat_q  <= 1'b0;
                end
                ST_LOAD: begin
                    sh_q  <= cur_word;
                    bit_q <= '0;
                end
                ST_CLK_LO: if (tmr_exp) begin
                    dat_q <= sh_q[WORD_W-1];
                    sh_q  <= sh_q << 1;
                end
                ST_CLK_HI: if (tmr_exp && bit_q != LAST_BIT)
                    bit_q <= bit_q + 1'b1;
                ST_LATCH: if (tmr_exp && word_q != LAST_WORD) begin
                    word_q <= word_q + 1'b1;
                    dat_q  <= 1'b0;
                end
                ST_SETUP, ST_TAIL, ST_FINISH: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ser_clk  = (state_q == ST_CLK_HI);
        ser_le   = (state_q == ST_LATCH);
        ser_data = dat_q;
        busy     = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done     = (state_q == ST_FINISH);
    end
endmodule

// File: rtl/pll_serial_loader_chk.sv
module pll_serial_loader_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_le,
    input logic busy,
    input logic done
);
    AST_DATA_STABLE_HI: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data)); // R2
    AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_data) |-> (!ser_clk && !$past(ser_clk))); // R2
    AST_LE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        ser_le |-> !ser_clk); // R4
    AST_LE_AFTER_TAIL: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_le) |-> !$past(ser_clk)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(ser_le))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_clk && !ser_le)); // R10
endmodule

bind pll_serial_loader pll_serial_loader_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_le(ser_le), .busy(busy), .done(done)
);

// File: tb/pll_serial_loader_tb.sv
module pll_serial_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETUP = 3;
    localparam int HOLD  = 2;
    localparam int LATCH = 4;
    localparam int WD_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [18:0] chan = '0;
    logic go = 1'b0;
    logic ser_clk, ser_data, ser_le, busy, done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_serial_loader #(.SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .LATCH_CYC(LATCH)) u_dut (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .go(go),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .busy(busy), .done(done)
    );

    // reference model: tuple {clk, data, le, busy, done}
    logic [4:0]  expq[$];
    logic [20:0] expw[$];
    logic        m_data = 1'b0;
    logic        m_fin  = 1'b0;
    logic        started = 1'b0;

    function automatic logic [20:0] nword_of(input logic [18:0] c, input logic g);
        logic [20:0] w;
        w = 21'((c / 32) << 7) | 21'((c % 32) << 2) | 21'd1;
        if (g) w = w | 21'h100000;
        return w;
    endfunction

    task automatic push_word(input logic [20:0] w);
        logic d = 1'b0;
        expq.push_back(5'b00010);                       // LOAD cycle (R7)
        for (int b = 20; b >= 0; b--) begin
            for (int i = 0; i < HOLD;  i++) expq.push_back({1'b0, d, 3'b010});
            d = w[b];
            for (int i = 0; i < SETUP; i++) expq.push_back({1'b0, d, 3'b010});
            for (int i = 0; i < HOLD;  i++) expq.push_back({1'b1, d, 3'b010});
        end
        for (int i = 0; i < HOLD;  i++) expq.push_back({1'b0, d, 3'b010});
        for (int i = 0; i < LATCH; i++) expq.push_back({1'b0, d, 3'b110});
        m_data = d;
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            expq.delete();
            expw.delete();
            m_data = 1'b0;
            m_fin  = 1'b0;
        end else if (m_fin) begin
            m_fin = 1'b0;                               // FINISH cycle ignores start
        end else if (expq.size() == 0 && start) begin
            logic [20:0] seq [4];
            seq[0] = 21'h001500;
            seq[1] = nword_of(chan, go);
            seq[2] = 21'h000093;
            seq[3] = 21'h000092;
            for (int k = 0; k < 4; k++) begin
                push_word(seq[k]);
                expw.push_back(seq[k]);
            end
            expq.push_back({1'b0, m_data, 3'b001});
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            logic [4:0] e, a;
            if (expq.size() != 0) e = expq.pop_front();
            else                  e = {1'b0, m_data, 3'b000};
            if (e[0]) m_fin = 1'b1;
            a = {ser_clk, ser_data, ser_le, busy, done};
            checks++;
            if (a !== e) begin
                fails++;
                if (a[4] !== e[4]) $display("FAIL R2: ser_clk got %b exp %b at %0t", a[4], e[4], $time);
                if (a[3] !== e[3]) $display("FAIL R1: ser_data got %b exp %b at %0t", a[3], e[3], $time);
                if (a[2] !== e[2]) $display("FAIL R4: ser_le got %b exp %b at %0t", a[2], e[2], $time);
                if (a[1] !== e[1]) $display("FAIL R8: busy got %b exp %b at %0t", a[1], e[1], $time);
                if (a[0] !== e[0]) $display("FAIL R9: done got %b exp %b at %0t", a[0], e[0], $time);
            end
        end
    end

    // receiver-side capture: rebuild each word from rising serial clocks
    logic        prev_clk = 1'b0, prev_le = 1'b0;
    logic [20:0] cap = '0;
    int          ncap = 0;
    int          widx = 0;
    int          latches = 0;
    always @(negedge clk) begin
        if (rst) begin
            cap = '0; ncap = 0; widx = 0;
        end else begin
            if (ser_clk && !prev_clk) begin
                if (ser_le) begin
                    checks++; fails++;
                    $display("FAIL R3: ser_le got 1 exp 0 while shifting");
                end
                cap = {cap[19:0], ser_data};
                ncap++;
            end
            if (ser_le && !prev_le) begin
                logic [20:0] ew;
                ew = (expw.size() != 0) ? expw.pop_front() : 21'h1fffff;
                checks++;
                if (ncap != 21) begin
                    fails++;
                    $display("FAIL R1: bits per word got %0d exp 21", ncap);
                end
                checks++;
                if (cap !== ew) begin
                    fails++;
                    if (widx == 1) $display("FAIL R5/R6/R11: divider word got %h exp %h", cap, ew);
                    else           $display("FAIL R7: word %0d got %h exp %h", widx, cap, ew);
                end
                widx = (widx + 1) % 4;
                latches++;
                cap = '0; ncap = 0;
            end
        end
        prev_clk = ser_clk;
        prev_le  = ser_le;
    end

    task automatic check_bit(input string req, input logic got, input logic exp_v);
        checks++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s: got %b exp %b", req, got, exp_v);
        end
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run(input logic [18:0] c, input logic g);
        @(negedge clk);
        chan = c; go = g; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_bit("R8", busy, 1'b1);
        wait_done();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check_bit("R10", ser_clk, 1'b0);
        check_bit("R10", ser_le, 1'b0);
        check_bit("R10", ser_data, 1'b0);
        check_bit("R10", busy, 1'b0);
        rst = 1'b0;

        // R5: nominal channel 32240 (A=16, B=1007)
        latches = 0;
        run(19'd32240, 1'b0);
        check_bit("R7", (latches == 4), 1'b1);

        // R6, R8, R11: go set, start and chan/go changed mid-run
        @(negedge clk);
        chan = 19'h7ffff; go = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        chan = 19'h00005; go = 1'b0; start = 1'b1;        // ignored (R8, R11)
        @(negedge clk);
        start = 1'b0;
        wait_done();
        start = 1'b1;                                    // start in FINISH ignored (R8)
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R8", busy, 1'b0);

        // R5 boundary: A at its maximum, B zero; then B=1, A=0
        run(19'd31, 1'b0);
        run(19'd32, 1'b1);

        // R10: reset in the middle of a word
        @(negedge clk);
        chan = 19'd1000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_bit("R10", ser_clk, 1'b0);
        check_bit("R10", ser_le, 1'b0);
        check_bit("R10", ser_data, 1'b0);
        check_bit("R10", busy, 1'b0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // sequence still works after reset
        run(19'd12345, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL R8: watchdog expired, got busy %b exp 0", busy);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule